// File: doc/BRIEF.md
# Rolled Four-Tap FIR Filter

This block computes one output of a four-tap finite impulse response filter per call. A caller places a new sample and four coefficients on the inputs and pulses `start`. The block then clears its accumulator and walks the taps from index 3 down to index 0, one tap per clock. All four taps share a single multiply-accumulate unit. In the same walk it shifts its delay line, and that delay line keeps its history from one call to the next. When the walk ends, the final sum is registered on `result` and `done` pulses.

Data moves through a plain call handshake rather than a stream. `idle` high means the block accepts `start` on the next rising edge. The block latches the sample when it accepts the call. The caller must hold the coefficient inputs steady until `done`, because they are read tap by tap during the walk. There is no back-pressure on the result. The value stays on `result` until the next call completes, so the caller may read it at any later time.

Top module: `fir4_rolled`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) drives `result` to 0, `idle` to 1, `done` and `ready` to 0, and clears all delay-line entries to 0, so the first call after reset returns coef0 times the sample.
- R2: `start` is accepted only at a rising edge where `idle` is 1. In the cycle after acceptance, `ready` is 1 for exactly one cycle and `idle` is 0.
- R3: `done` is 1 for exactly one cycle, in the cycle that follows the sixth rising edge after acceptance. `idle` stays 0 from acceptance until that cycle and is 1 again with `done`.
- R4: With d0..d2 the three most recent earlier samples (d0 the newest), `result` = coef0*x + coef1*d0 + coef2*d1 + coef3*d2. Each coefficient is a signed 16-bit field of `coef_flat`, with coef k at bits [16k+15:16k].
- R5: The delay line persists between calls. Each call shifts it by exactly one position, and the new sample enters entry 0.
- R6: `start` while a call is in progress has no effect. Timing, the result and the stored history are as if it had not been asserted.
- R7: The 34-bit signed accumulator cannot overflow. Four products of -32768 by -32768 give +4294967296.
- R8: `result` changes only in the cycle in which `done` is 1, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Call request, sampled while idle |
| sample_in | input | 16 | New signed sample, latched on acceptance |
| coef_flat | input | 64 | Four signed 16-bit coefficients, coef k in bits [16k+15:16k] |
| result | output | 34 | Signed filter output, updated with `done` |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | High when no call is in progress |
| ready | output | 1 | One-cycle pulse: inputs of the accepted call consumed |

## Verification
The hardest condition to reach from the ports is a `start` pulse arriving mid-walk, with a different sample value, while the delay line holds known non-zero history. If that pulse is wrongly taken, it corrupts either the current sum or the stored history. The stimulus first primes the history with several calls. It then pulses `start` in the middle of the tap walk with a distinct sample. It checks that the current result, the `done` timing and the next call's result all match the values expected had the pulse never occurred. Full-scale negative operands are driven through four consecutive calls to reach the largest accumulator value.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_WALK = 2'd2,
    ST_END  = 2'd3
  } fir_state_e;

  function automatic int acc_width(input int data_w, input int taps);
    return 2 * data_w + $clog2(taps);
  endfunction

endpackage

// File: rtl/fir4_ctrl.sv
module fir4_ctrl
  import fir4_pkg::*;
#(
  parameter int TAPS  = 4,
  parameter int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             accept,
  output logic             idle,
  output logic             ready,
  output logic             done,
  output logic             acc_clear,
  output logic             step_en,
  output logic             load_result,
  output logic [IDX_W-1:0] tap_idx
);

  fir_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_END);
      unique case (state_q)
        ST_IDLE: if (start) state_q <= ST_INIT;
        ST_INIT: begin
          state_q <= ST_WALK;
          idx_q   <= IDX_W'(TAPS - 1);
        end
        ST_WALK: begin
          if (idx_q == '0) state_q <= ST_END;
          else             idx_q   <= idx_q - 1'b1;
        end
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle        = (state_q == ST_IDLE);
  assign accept      = idle && start;
  assign ready       = (state_q == ST_INIT);
  assign acc_clear   = (state_q == ST_INIT);
  assign step_en     = (state_q == ST_WALK);
  assign load_result = (state_q == ST_END);
  assign done        = done_q;
  assign tap_idx     = idx_q;

endmodule

// File: rtl/fir4_delay.sv
module fir4_delay #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 4,
  parameter int IDX_W  = $clog2(TAPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en,
  input  logic [IDX_W-1:0]         tap_idx,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] operand
);

  logic signed [DATA_W-1:0] line_q [TAPS];

  for (genvar k = 0; k < TAPS; k++) begin : g_entry
    logic signed [DATA_W-1:0] src;
    if (k == 0) begin : g_head
      assign src = sample;
    end else begin : g_body
      assign src = line_q[k-1];
    end
    always_ff @(posedge clk) begin
      if (rst)                                       line_q[k] <= '0;
      else if (shift_en && tap_idx == IDX_W'(k))     line_q[k] <= src;
    end
  end

  // Operand for tap i is the value entry i receives: the new sample at i == 0.
  always_comb begin
    operand = sample;
    for (int k = 1; k < TAPS; k++) begin
      if (tap_idx == IDX_W'(k)) operand = line_q[k-1];
    end
  end

endmodule

// File: rtl/fir4_mac.sv
module fir4_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 34
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] a,
  input  logic signed [DATA_W-1:0] b,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod     = a * b;
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || clear) acc_q <= '0;
    else if (en)      acc_q <= acc_q + prod_ext;
  end

  assign acc = acc_q;

endmodule

// File: rtl/fir4_rolled.sv
module fir4_rolled
  import fir4_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAPS   = 4,
  parameter int ACC_W  = acc_width(DATA_W, TAPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DATA_W-1:0]      sample_in,
  input  logic [TAPS*DATA_W-1:0] coef_flat,
  output logic [ACC_W-1:0]       result,
  output logic                   done,
  output logic                   idle,
  output logic                   ready
);

  localparam int IDX_W = $clog2(TAPS);

  logic                     accept, acc_clear, step_en, load_result;
  logic [IDX_W-1:0]         tap_idx;
  logic signed [DATA_W-1:0] sample_q, operand, coef_sel;
  logic signed [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]         result_q;

  fir4_ctrl #(.TAPS(TAPS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .idle(idle), .ready(ready), .done(done),
    .acc_clear(acc_clear), .step_en(step_en),
    .load_result(load_result), .tap_idx(tap_idx)
  );

  always_ff @(posedge clk) begin
    if (rst)         sample_q <= '0;
    else if (accept) sample_q <= sample_in;
  end

  always_comb begin
    coef_sel = '0;
    for (int k = 0; k < TAPS; k++) begin
      if (tap_idx == IDX_W'(k)) coef_sel = coef_flat[k*DATA_W +: DATA_W];
    end
  end

  fir4_delay #(.DATA_W(DATA_W), .TAPS(TAPS), .IDX_W(IDX_W)) u_delay (
    .clk(clk), .rst(rst), .shift_en(step_en), .tap_idx(tap_idx),
    .sample(sample_q), .operand(operand)
  );

  fir4_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst(rst), .clear(acc_clear), .en(step_en),
    .a(operand), .b(coef_sel), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst)              result_q <= '0;
    else if (load_result) result_q <= acc;
  end

  assign result = result_q;

endmodule

// File: rtl/fir4_rolled_chk.sv
module fir4_rolled_chk #(
  parameter int TAPS  = 4,
  parameter int ACC_W = 34
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             idle,
  input logic             ready,
  input logic             done,
  input logic [ACC_W-1:0] result
);

  logic [7:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || idle) busy_cnt <= '0;
    else             busy_cnt <= busy_cnt + 1'b1;
  end

  a_r2_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r2_ready_after_accept: assert property (@(posedge clk) disable iff (rst)
    ready |-> $past(idle && start));

  a_r2_ready_not_idle: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ready, idle}));

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r3_done_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (idle && busy_cnt == 8'(TAPS + 2)));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    !idle |-> busy_cnt <= 8'(TAPS + 1));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

endmodule

bind fir4_rolled fir4_rolled_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .idle(idle),
  .ready(ready), .done(done), .result(result)
);

// File: tb/fir4_rolled_tb.sv
module fir4_rolled_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] sample_in = '0;
  logic [63:0] coef_flat = '0;
  logic [33:0] result;
  logic        done, idle, ready;

  int checks = 0;
  int failures = 0;
  longint hist [3];

  always #10 clk = ~clk;

  fir4_rolled u_dut (
    .clk(clk), .rst(rst), .start(start), .sample_in(sample_in),
    .coef_flat(coef_flat), .result(result), .done(done),
    .idle(idle), .ready(ready)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic longint res_s();
    return longint'($signed(result));
  endfunction

  function automatic longint cf(input int k);
    return longint'($signed(coef_flat[k*16 +: 16]));
  endfunction

  task automatic set_coefs(input int c0, input int c1, input int c2, input int c3);
    coef_flat = {16'(c3), 16'(c2), 16'(c1), 16'(c0)};
  endtask

  // One call; poke drives a start with a different sample mid-walk.
  task automatic do_call(input int x, input bit poke, input string tag);
    longint exp, held;
    exp = cf(0) * longint'(x) + cf(1) * hist[0] + cf(2) * hist[1] + cf(3) * hist[2];
    held = res_s();
    @(negedge clk);
    start = 1'b1;
    sample_in = 16'(x);
    @(negedge clk);
    chk({"R2 ready ", tag}, longint'(ready), 1);
    chk({"R2 idle low ", tag}, longint'(idle), 0);
    start = 1'b0;
    sample_in = 16'h5a5a;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (poke && i == 1) start = 1'b1;
      else start = 1'b0;
      if (i == 1) chk({"R6 idle during walk ", tag}, longint'(idle), 0);
    end
    start = 1'b0;
    chk({"R3 done not early ", tag}, longint'(done), 0);
    chk({"R8 result held ", tag}, res_s(), held);
    @(negedge clk);
    chk({"R3 done ", tag}, longint'(done), 1);
    chk({"R3 idle back ", tag}, longint'(idle), 1);
    chk({"R4 result ", tag}, res_s(), exp);
    @(negedge clk);
    chk({"R3 done one cycle ", tag}, longint'(done), 0);
    chk({"R8 result stable ", tag}, res_s(), exp);
    chk({"R6 no stray call ", tag}, longint'(ready), 0);
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = longint'(x);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 result", res_s(), 0);
    chk("R1 idle", longint'(idle), 1);
    chk("R1 done", longint'(done), 0);
    chk("R1 ready", longint'(ready), 0);
    foreach (hist[k]) hist[k] = 0;
    set_coefs(3, 5, 7, 11);
    do_call(9, 1'b0, "R1 first call");
    chk("R1 cleared history", res_s(), 27);
  endtask

  task automatic t_sequence();
    set_coefs(1, 2, 3, 4);
    do_call(5, 1'b0, "R5 a");
    do_call(-7, 1'b0, "R5 b");
    do_call(100, 1'b0, "R5 c");
    set_coefs(-2, 0, 9, -1);
    do_call(-300, 1'b0, "R5 d");
    chk("R5 history shift", hist[1], 100);
  endtask

  task automatic t_busy_start();
    set_coefs(4, -3, 2, 1);
    do_call(21, 1'b1, "R6 poked");
    do_call(0, 1'b0, "R6 after poke");
  endtask

  task automatic t_fullscale();
    set_coefs(-32768, -32768, -32768, -32768);
    for (int i = 0; i < 4; i++) do_call(-32768, 1'b0, "R7 full scale");
    chk("R7 max sum", res_s(), 64'sd4294967296);
    set_coefs(32767, 32767, 32767, 32767);
    do_call(32767, 1'b0, "R7 mixed sign");
  endtask

  task automatic t_idle_start_hold();
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 no call without start", longint'(idle), 1);
    chk("R8 idle hold", longint'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_sequence();
    t_busy_start();
    t_fullscale();
    t_idle_start_hold();
    finish_run();
  end

endmodule